// File: doc/BRIEF.md
# Secure Reset Configuration Latch

This block fixes the chip's operating configuration at the moment reset is released. While reset is held, it watches a configuration-override strobe, a sampled external data bus and a security-enabled flag. On the first rising clock edge with reset released it captures a configuration record and holds it until the next reset. The record holds a boot mode, two clock-generator selection bits, a load bit and five general configuration bits. A boot vector address is decoded from the captured mode.

With the strobe low, every field takes a fixed default. With the strobe high and security off, every field is copied from its assigned bus pin. With security on, the boot mode is forced to single-chip, which keeps the external bus closed and boots from internal address 0. Only the two clock-generator bits and the load bit still accept an override. The general bits keep their defaults. The security flag is sampled on the same edge as the pins.

Top module: `secure_rcfg_latch`

## Requirements
- R1: While rst_ni is low, the outputs show the default record: mode 3'b000 (single-chip), pll_sel 1, pll_ref 1, load 0, misc 5'b10010, vector 32'h0000_0000.
- R2: The record is captured on the first rising clk_i edge with rst_ni high. Afterwards, changes on secure_i, cfg_strobe_i or bus_i do not alter any output until the next reset.
- R3: With secure_i low and cfg_strobe_i high at capture, boot_mode_o = {bus_i[26], bus_i[17], bus_i[16]}, pll_sel_o = bus_i[23], pll_ref_o = bus_i[22], load_o = bus_i[21], and cfg_misc_o = {bus_i[25], bus_i[24], bus_i[20], bus_i[19], bus_i[18]}.
- R4: With cfg_strobe_i low at capture and secure_i low, all fields take the R1 defaults, whatever bus_i holds.
- R5: With secure_i high at capture, boot_mode_o is 3'b000 (single-chip), regardless of cfg_strobe_i and bus_i.
- R6: With secure_i and cfg_strobe_i both high at capture, pll_sel_o, pll_ref_o and load_o still follow bus_i[23], bus_i[22] and bus_i[21].
- R7: With secure_i high at capture, cfg_misc_o keeps its default 5'b10010, regardless of cfg_strobe_i and bus_i.
- R8: boot_vec_o is 32'h0000_0000 when boot_mode_o is 3'b000. For every other mode code it is 32'h2000_0000.
- R9: Only the value of secure_i on the capture edge counts. A value held earlier in reset and then changed has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| secure_i | input | 1 | Security enabled |
| cfg_strobe_i | input | 1 | Configuration override strobe, active high |
| bus_i | input | 32 | Sampled external data bus |
| boot_mode_o | output | 3 | Captured boot mode, 3'b000 = single-chip |
| boot_vec_o | output | 32 | Boot vector address |
| pll_sel_o | output | 1 | Clock-generator select bit |
| pll_ref_o | output | 1 | Clock-generator reference bit |
| load_o | output | 1 | Load configuration bit |
| cfg_misc_o | output | 5 | General configuration bits |

## Verification
The armed flag decides whether a capture is still pending. If it stays set, the outputs follow bus changes after the capture edge, and the hold check a few cycles later reports this. If it is never set, the defaults remain after release. A filter that misroutes a pin, or that leaks a field while security is on, shows in the first cycle after the capture edge. It appears on the mode, on the vector and on the affected bit. Each case is checked in that cycle.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
  localparam int MODE_W = 3;
  localparam int MISC_W = 5;

  localparam logic [MODE_W-1:0] MODE_SINGLE = 3'b000;

  // bus pin assignment per field; element 0 drives field bit 0
  localparam int MODE_PIN [MODE_W] = '{16, 17, 26};
  localparam int MISC_PIN [MISC_W] = '{18, 19, 20, 24, 25};
  localparam int PLL_SEL_PIN = 23;
  localparam int PLL_REF_PIN = 22;
  localparam int LOAD_PIN    = 21;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              pll_sel;
    logic              pll_ref;
    logic              load;
    logic [MISC_W-1:0] misc;
  } rcfg_t;

  localparam rcfg_t DEFAULT_CFG = '{
    mode:    MODE_SINGLE,
    pll_sel: 1'b1,
    pll_ref: 1'b1,
    load:    1'b0,
    misc:    5'b10010
  };
endpackage

// File: rtl/rcfg_filter.sv
module rcfg_filter
  import rcfg_pkg::*;
#(
  parameter int    BUS_W   = 32,
  parameter rcfg_t DEF_CFG = DEFAULT_CFG
) (
  input  logic             secure_i,
  input  logic             strobe_i,
  input  logic [BUS_W-1:0] bus_i,
  output rcfg_t            cfg_o
);
  wire [MODE_W-1:0] mode_pins;
  wire [MISC_W-1:0] misc_pins;

  genvar g;
  generate
    for (g = 0; g < MODE_W; g++) begin : g_mode
      assign mode_pins[g] = bus_i[MODE_PIN[g]];
    end
    for (g = 0; g < MISC_W; g++) begin : g_misc
      assign misc_pins[g] = bus_i[MISC_PIN[g]];
    end
  endgenerate

  logic unused_bus;
  assign unused_bus = ^bus_i;

  always_comb begin
    cfg_o = DEF_CFG;
    if (strobe_i) begin
      // clock and load overrides are allowed in both security states
      cfg_o.pll_sel = bus_i[PLL_SEL_PIN];
      cfg_o.pll_ref = bus_i[PLL_REF_PIN];
      cfg_o.load    = bus_i[LOAD_PIN];
      if (!secure_i) begin
        cfg_o.mode = mode_pins;
        cfg_o.misc = misc_pins;
      end
    end
    // never expose the external bus while secure
    if (secure_i) cfg_o.mode = MODE_SINGLE;
  end
endmodule

// File: rtl/rcfg_capture.sv
module rcfg_capture
  import rcfg_pkg::*;
#(
  parameter rcfg_t DEF_CFG = DEFAULT_CFG
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  rcfg_t cfg_d_i,
  output rcfg_t cfg_q_o,
  output logic  armed_o
);
  rcfg_t cfg_q;
  logic  armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= DEF_CFG;
      armed_q <= 1'b1;
    end else if (armed_q) begin
      cfg_q   <= cfg_d_i;
      armed_q <= 1'b0;
    end
  end

  assign cfg_q_o = cfg_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/rcfg_vector.sv
module rcfg_vector
  import rcfg_pkg::*;
#(
  parameter int                 VEC_W   = 32,
  parameter logic [VEC_W-1:0] INT_VEC = '0,
  parameter logic [VEC_W-1:0] EXT_VEC = 32'h2000_0000
) (
  input  logic [MODE_W-1:0] mode_i,
  output logic [VEC_W-1:0]  vec_o
);
  assign vec_o = (mode_i == MODE_SINGLE) ? INT_VEC : EXT_VEC;
endmodule

// File: rtl/secure_rcfg_latch.sv
module secure_rcfg_latch
  import rcfg_pkg::*;
#(
  parameter int                 BUS_W   = 32,
  parameter int                 VEC_W   = 32,
  parameter logic [VEC_W-1:0] INT_VEC = '0,
  parameter logic [VEC_W-1:0] EXT_VEC = 32'h2000_0000,
  parameter rcfg_t              DEF_CFG = DEFAULT_CFG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              secure_i,
  input  logic              cfg_strobe_i,
  input  logic [BUS_W-1:0]  bus_i,
  output logic [MODE_W-1:0] boot_mode_o,
  output logic [VEC_W-1:0]  boot_vec_o,
  output logic              pll_sel_o,
  output logic              pll_ref_o,
  output logic              load_o,
  output logic [MISC_W-1:0] cfg_misc_o
);
  rcfg_t cfg_d, cfg_q;
  logic  armed_w;

  rcfg_filter #(.BUS_W(BUS_W), .DEF_CFG(DEF_CFG)) u_filter (
    .secure_i (secure_i),
    .strobe_i (cfg_strobe_i),
    .bus_i    (bus_i),
    .cfg_o    (cfg_d)
  );

  rcfg_capture #(.DEF_CFG(DEF_CFG)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_d_i (cfg_d),
    .cfg_q_o (cfg_q),
    .armed_o (armed_w)
  );

  rcfg_vector #(.VEC_W(VEC_W), .INT_VEC(INT_VEC), .EXT_VEC(EXT_VEC)) u_vector (
    .mode_i (cfg_q.mode),
    .vec_o  (boot_vec_o)
  );

  assign boot_mode_o = cfg_q.mode;
  assign pll_sel_o   = cfg_q.pll_sel;
  assign pll_ref_o   = cfg_q.pll_ref;
  assign load_o      = cfg_q.load;
  assign cfg_misc_o  = cfg_q.misc;
endmodule

// File: rtl/secure_rcfg_chk.sv
module secure_rcfg_chk
  import rcfg_pkg::*;
#(
  parameter int    BUS_W   = 32,
  parameter int    VEC_W   = 32,
  parameter rcfg_t DEF_CFG = DEFAULT_CFG
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              secure_i,
  input logic              cfg_strobe_i,
  input logic [BUS_W-1:0]  bus_i,
  input logic [MODE_W-1:0] boot_mode_o,
  input logic [VEC_W-1:0]  boot_vec_o,
  input logic              pll_sel_o,
  input logic              pll_ref_o,
  input logic              load_o,
  input logic [MISC_W-1:0] cfg_misc_o,
  input logic              armed_i
);
  logic unused_bus;
  assign unused_bus = ^bus_i;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> $stable({boot_mode_o, pll_sel_o, pll_ref_o, load_o, cfg_misc_o})); // R2

  AST_STROBE_OFF_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i && !cfg_strobe_i |=> {boot_mode_o, pll_sel_o, pll_ref_o, load_o, cfg_misc_o} == DEF_CFG); // R4

  AST_OPEN_PLL_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i && !secure_i && cfg_strobe_i |=> pll_sel_o == $past(bus_i[PLL_SEL_PIN])); // R3

  AST_SECURE_SINGLE_CHIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i && secure_i |=> boot_mode_o == MODE_SINGLE); // R5

  AST_SECURE_LOAD_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i && secure_i && cfg_strobe_i |=> load_o == $past(bus_i[LOAD_PIN])); // R6

  AST_SECURE_MISC_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i && secure_i |=> cfg_misc_o == DEF_CFG.misc); // R7

  AST_SINGLE_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_mode_o == MODE_SINGLE |-> boot_vec_o == '0); // R8
endmodule

bind secure_rcfg_latch secure_rcfg_chk #(.BUS_W(BUS_W), .VEC_W(VEC_W), .DEF_CFG(DEF_CFG)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .secure_i     (secure_i),
  .cfg_strobe_i (cfg_strobe_i),
  .bus_i        (bus_i),
  .boot_mode_o  (boot_mode_o),
  .boot_vec_o   (boot_vec_o),
  .pll_sel_o    (pll_sel_o),
  .pll_ref_o    (pll_ref_o),
  .load_o       (load_o),
  .cfg_misc_o   (cfg_misc_o),
  .armed_i      (armed_w)
);

// File: tb/secure_rcfg_latch_tb_top.sv
`timescale 1ns/1ps
module secure_rcfg_latch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        secure = 1'b0;
  logic        strobe = 1'b0;
  logic [31:0] bus = '0;
  logic [2:0]  mode;
  logic [31:0] vec;
  logic        pll_sel, pll_ref, load;
  logic [4:0]  misc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  secure_rcfg_latch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .secure_i(secure), .cfg_strobe_i(strobe), .bus_i(bus),
    .boot_mode_o(mode), .boot_vec_o(vec), .pll_sel_o(pll_sel), .pll_ref_o(pll_ref),
    .load_o(load), .cfg_misc_o(misc)
  );

  typedef struct {
    logic [2:0]  mode;
    logic [31:0] vec;
    logic        ps, pr, ld;
    logic [4:0]  misc;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  event mon_ev;

  function automatic exp_t defaults(string tag);
    exp_t e;
    e.mode = 3'b000; e.vec = 32'h0; e.ps = 1'b1; e.pr = 1'b1; e.ld = 1'b0;
    e.misc = 5'b10010; e.tag = tag;
    return e;
  endfunction

  // expected record from the requirements
  function automatic exp_t model(bit sec, bit stb, logic [31:0] b, string tag);
    exp_t e = defaults(tag);
    if (stb) begin
      e.ps = b[23]; e.pr = b[22]; e.ld = b[21];
      if (!sec) begin
        e.mode = {b[26], b[17], b[16]};
        e.misc = {b[25], b[24], b[20], b[19], b[18]};
      end
    end
    if (sec) e.mode = 3'b000;
    e.vec = (e.mode == 3'b000) ? 32'h0000_0000 : 32'h2000_0000;
    return e;
  endfunction

  // monitor: pops one expected item per event and compares the ports
  initial forever begin
    exp_t e;
    @(mon_ev);
    e = sb_q.pop_front();
    n_cmp++;
    if (mode !== e.mode || vec !== e.vec || pll_sel !== e.ps || pll_ref !== e.pr ||
        load !== e.ld || misc !== e.misc) begin
      n_bad++;
      $display("FAIL %s: got mode=%b vec=%h ps=%b pr=%b ld=%b misc=%b exp mode=%b vec=%h ps=%b pr=%b ld=%b misc=%b",
               e.tag, mode, vec, pll_sel, pll_ref, load, misc,
               e.mode, e.vec, e.ps, e.pr, e.ld, e.misc);
    end
  end

  task automatic push_and_check(exp_t e);
    sb_q.push_back(e);
    ->mon_ev;
    #1;
  endtask

  task automatic run_case(bit sec_early, bit sec_final, bit stb, logic [31:0] b, string tag);
    @(negedge clk);
    rst_n = 1'b0; secure = sec_early; strobe = stb; bus = b;
    repeat (2) @(negedge clk);
    push_and_check(defaults({tag, " R1 reset"}));
    secure = sec_final;
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    push_and_check(model(sec_final, stb, b, tag));
    secure = ~sec_final; strobe = ~stb; bus = ~b;
    repeat (4) @(negedge clk);
    push_and_check(model(sec_final, stb, b, {tag, " R2 hold"}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    run_case(0, 0, 1, 32'hFFFF_FFFF, "R3 R8 all ones");
    run_case(0, 0, 1, 32'h0000_0000, "R3 R8 all zeros");
    run_case(0, 0, 1, 32'h0002_0000, "R3 R8 single mode pin");
    run_case(0, 0, 1, 32'h0348_0000, "R3 misc pins");
    run_case(0, 0, 0, 32'hFFFF_FFFF, "R4 no strobe");
    run_case(1, 1, 1, 32'hFFFF_FFFF, "R5 R6 R7 secure ones");
    run_case(1, 1, 1, 32'h0000_0000, "R6 R7 secure zeros");
    run_case(1, 1, 0, 32'hFFFF_FFFF, "R5 R7 secure no strobe");
    run_case(1, 0, 1, 32'h0420_0000, "R9 secure dropped");
    run_case(0, 1, 1, 32'h0420_0000, "R9 secure raised");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule